// File: doc/BRIEF.md
# Byte ALU with Full-Width Multiply

This block is a purely combinational arithmetic-logic unit for two 8-bit operands. A 3-bit operation select picks addition, subtraction, unsigned multiplication, bitwise AND or bitwise OR. The block returns a 16-bit result together with a carry flag and a zero flag. Because the result is twice the operand width, an 8x8 multiply produces its whole product in a single operation.

The narrow operations (add, subtract, AND, OR) return an 8-bit value zero-extended into the 16-bit result. For add and subtract, the carry flag reports the carry out or the borrow. The three unassigned select codes return a defined all-zero result, so a stray code can never pass on stale or partial data.

A surrounding datapath drives the operands and the select. It reads the result and flags in the same cycle, because the block holds no state.

Top module: `byte_alu`

## Requirements
- R1: Select 3'b000 adds. result[7:0] is (A + B) mod 256, result[15:8] is zero, and C is the carry out of bit 7.
- R2: Select 3'b001 subtracts. result[7:0] is (A - B) mod 256, result[15:8] is zero, and C is 1 exactly when A < B (a borrow).
- R3: Select 3'b010 multiplies as unsigned numbers. result is the full 16-bit product A*B, and C is 1 exactly when result[15:8] is nonzero.
- R4: Select 3'b011 gives the bitwise AND in result[7:0], with result[15:8] zero and C equal to 0.
- R5: Select 3'b100 gives the bitwise OR in result[7:0], with result[15:8] zero and C equal to 0.
- R6: For every select value, Z is 1 exactly when all 16 result bits are zero.
- R7: Selects 3'b101, 3'b110 and 3'b111 give result 0, C 0 and Z 1, whatever the operand values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 8 | First operand (A); the minuend for subtraction |
| opnd_b | input | 8 | Second operand (B); the subtrahend for subtraction |
| op_sel | input | 3 | Operation select code |
| result | output | 16 | Operation result |
| carry_o | output | 1 | Carry, borrow or product-overflow flag (C) |
| zero_o | output | 1 | Set when result is all zeros (Z) |

## Verification
Every select code is driven with a grid of corner operands: 0, 1, 0x7F, 0x80, 0xFF, 0x55 and 0xAA in all pairings. This grid separates carry from no-carry at the 0xFF/0x01 boundary, borrow from equal operands, and products that fit in one byte from those that spill into the upper byte. The alternating patterns 0x55 and 0xAA tell AND and OR apart from each other and from swapped operands. Random operands per select then cover general mixes. The reserved codes are driven with nonzero operands, so that any leak from an operand shows up on the result or the flags.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

    parameter int unsigned ALU_DW = 8;
    localparam int unsigned SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_ADD  = 3'b000,
        SEL_SUB  = 3'b001,
        SEL_MUL  = 3'b010,
        SEL_AND  = 3'b011,
        SEL_OR   = 3'b100,
        SEL_RES5 = 3'b101,
        SEL_RES6 = 3'b110,
        SEL_RES7 = 3'b111
    } alu_sel_e;

    // The OR path of the logic unit is picked by this select only.
    function automatic logic sel_is_or(input alu_sel_e s);
        return (s == SEL_OR);
    endfunction

    // The adder runs in subtract mode for this select only.
    function automatic logic sel_is_sub(input alu_sel_e s);
        return (s == SEL_SUB);
    endfunction

endpackage

// File: rtl/byte_alu_addsub.sv
module byte_alu_addsub #(
    parameter int unsigned DW = 8
) (
    input  logic [DW-1:0] lhs,
    input  logic [DW-1:0] rhs,
    input  logic          do_sub,
    output logic [DW-1:0] sum,
    output logic          flag
);
    // Ripple chain; in subtract mode rhs is inverted and carry-in is one.
    logic [DW:0]   chain;
    logic [DW-1:0] rhs_x;

    assign rhs_x    = rhs ^ {DW{do_sub}};
    assign chain[0] = do_sub;

    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign sum[i]     = lhs[i] ^ rhs_x[i] ^ chain[i];
        assign chain[i+1] = (lhs[i] & rhs_x[i]) | (lhs[i] & chain[i]) | (rhs_x[i] & chain[i]);
    end

    // Carry out for add; the inverted carry is the borrow for subtract.
    assign flag = chain[DW] ^ do_sub;
endmodule

// File: rtl/byte_alu_mul.sv
module byte_alu_mul #(
    parameter int unsigned DW = 8
) (
    input  logic [DW-1:0]   mcand,
    input  logic [DW-1:0]   mplier,
    output logic [2*DW-1:0] prod
);
    localparam int unsigned PW = 2 * DW;

    logic [PW-1:0] row [DW];
    logic [PW-1:0] acc [DW];

    // One shifted partial-product row per multiplier bit.
    for (genvar i = 0; i < DW; i++) begin : g_row
        assign row[i] = {{DW{1'b0}}, (mcand & {DW{mplier[i]}})} << i;
    end

    // Accumulate the rows one after another.
    assign acc[0] = row[0];
    for (genvar i = 1; i < DW; i++) begin : g_acc
        assign acc[i] = acc[i-1] + row[i];
    end

    assign prod = acc[DW-1];
endmodule

// File: rtl/byte_alu_logic.sv
module byte_alu_logic #(
    parameter int unsigned DW = 8
) (
    input  logic [DW-1:0] lhs,
    input  logic [DW-1:0] rhs,
    input  logic          pick_or,
    output logic [DW-1:0] bits
);
    assign bits = pick_or ? (lhs | rhs) : (lhs & rhs);
endmodule

// File: rtl/byte_alu.sv
module byte_alu
    import byte_alu_pkg::*;
#(
    parameter int unsigned DW = ALU_DW
) (
    input  logic [DW-1:0]   opnd_a,
    input  logic [DW-1:0]   opnd_b,
    input  logic [2:0]      op_sel,
    output logic [2*DW-1:0] result,
    output logic            carry_o,
    output logic            zero_o
);
    localparam int unsigned RW = 2 * DW;

    typedef struct packed {
        logic          cy;
        logic [RW-1:0] val;
    } lane_t;

    alu_sel_e      sel;
    logic [DW-1:0] as_sum;
    logic          as_flag;
    logic [RW-1:0] mul_p;
    logic [DW-1:0] lg_bits;
    lane_t         out_lane;

    assign sel = alu_sel_e'(op_sel);

    byte_alu_addsub #(.DW(DW)) u_addsub (
        .lhs    (opnd_a),
        .rhs    (opnd_b),
        .do_sub (sel_is_sub(sel)),
        .sum    (as_sum),
        .flag   (as_flag)
    );

    byte_alu_mul #(.DW(DW)) u_mul (
        .mcand  (opnd_a),
        .mplier (opnd_b),
        .prod   (mul_p)
    );

    byte_alu_logic #(.DW(DW)) u_logic (
        .lhs     (opnd_a),
        .rhs     (opnd_b),
        .pick_or (sel_is_or(sel)),
        .bits    (lg_bits)
    );

    always_comb begin
        out_lane = '0;
        unique case (sel)
            SEL_ADD, SEL_SUB: begin
                out_lane.val = {{DW{1'b0}}, as_sum};
                out_lane.cy  = as_flag;
            end
            SEL_MUL: begin
                out_lane.val = mul_p;
                out_lane.cy  = |mul_p[RW-1:DW];
            end
            SEL_AND, SEL_OR: begin
                out_lane.val = {{DW{1'b0}}, lg_bits};
                out_lane.cy  = 1'b0;
            end
            default: out_lane = '0;
        endcase
    end

    assign result  = out_lane.val;
    assign carry_o = out_lane.cy;
    assign zero_o  = ~|out_lane.val;
endmodule

// File: rtl/byte_alu_chk.sv
module byte_alu_chk #(
    parameter int unsigned DW = 8
) (
    input logic [DW-1:0]   opnd_a,
    input logic [DW-1:0]   opnd_b,
    input logic [2:0]      op_sel,
    input logic [2*DW-1:0] result,
    input logic            carry_o,
    input logic            zero_o
);
    always_comb begin
        if (!$isunknown({opnd_a, opnd_b, op_sel, result, carry_o, zero_o})) begin
            if (op_sel == 3'b000) begin
                AST_ADD_SUM: assert ({carry_o, result[DW-1:0]} == ({1'b0, opnd_a} + {1'b0, opnd_b}) && result[2*DW-1:DW] == '0) else $error("add mismatch"); // R1
            end
            if (op_sel == 3'b001) begin
                AST_SUB_BORROW: assert (carry_o == (opnd_a < opnd_b) && result[DW-1:0] == DW'(opnd_a - opnd_b) && result[2*DW-1:DW] == '0) else $error("sub mismatch"); // R2
            end
            if (op_sel == 3'b010) begin
                AST_MUL_PROD: assert (result == (2*DW)'(opnd_a) * (2*DW)'(opnd_b) && carry_o == (result >= (2*DW)'(1 << DW))) else $error("mul mismatch"); // R3
            end
            if (op_sel == 3'b011) begin
                AST_AND_BITS: assert (result == {{DW{1'b0}}, opnd_a & opnd_b} && !carry_o) else $error("and mismatch"); // R4
            end
            if (op_sel == 3'b100) begin
                AST_OR_BITS: assert (result == {{DW{1'b0}}, opnd_a | opnd_b} && !carry_o) else $error("or mismatch"); // R5
            end
            AST_ZERO_FLAG: assert (zero_o == (result == '0)) else $error("zero flag mismatch"); // R6
            if (op_sel > 3'b100) begin
                AST_RESERVED_IDLE: assert (result == '0 && !carry_o && zero_o) else $error("reserved select leaked"); // R7
            end
        end
    end
endmodule

bind byte_alu byte_alu_chk #(.DW(DW)) chk_i (.*);

// File: tb/byte_alu_tb_top.sv
module byte_alu_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  opnd_a = '0;
    logic [7:0]  opnd_b = '0;
    logic [2:0]  op_sel = '0;
    logic [15:0] result;
    logic        carry_o;
    logic        zero_o;

    int n_cmp  = 0;
    int n_bad  = 0;
    bit done   = 0;

    // Reference queues filled at the drive edge, drained half a period later.
    int q_res[$];
    int q_c[$];
    int q_op[$];

    byte_alu dut_i (
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b),
        .op_sel  (op_sel),
        .result  (result),
        .carry_o (carry_o),
        .zero_o  (zero_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic string tag_of(input int op);
        case (op)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            default: return "R7";
        endcase
    endfunction

    task automatic apply(input int op, input int a, input int b);
        int r;
        int c;
        @(posedge clk);
        op_sel = op[2:0];
        opnd_a = a[7:0];
        opnd_b = b[7:0];
        case (op)
            0: begin r = (a + b) % 256; c = ((a + b) > 255) ? 1 : 0; end
            1: begin r = (a - b + 256) % 256; c = (a < b) ? 1 : 0; end
            2: begin r = a * b; c = (r > 255) ? 1 : 0; end
            3: begin r = a & b; c = 0; end
            4: begin r = a | b; c = 0; end
            default: begin r = 0; c = 0; end
        endcase
        q_res.push_back(r);
        q_c.push_back(c);
        q_op.push_back(op);
    endtask

    always @(negedge clk) begin
        if (!rst && q_res.size() > 0) begin
            int er;
            int ec;
            int eo;
            int ez;
            er = q_res.pop_front();
            ec = q_c.pop_front();
            eo = q_op.pop_front();
            ez = (er == 0) ? 1 : 0;
            n_cmp++;
            if (int'(result) != er || int'(carry_o) != ec) begin
                n_bad++;
                $display("FAIL %s op=%0d a=%02h b=%02h: result=%04h C=%0d, expected result=%04h C=%0d",
                         tag_of(eo), eo, opnd_a, opnd_b, result, carry_o, er, ec);
            end
            n_cmp++;
            if (int'(zero_o) != ez) begin
                n_bad++;
                $display("FAIL R6 op=%0d a=%02h b=%02h: Z=%0d, expected Z=%0d",
                         eo, opnd_a, opnd_b, zero_o, ez);
            end
        end
    end

    initial begin
        int corner[7] = '{0, 1, 8'h7F, 8'h80, 8'hFF, 8'h55, 8'hAA};
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Reset state: zero operands with add give zero result and Z set (R6).
        apply(0, 0, 0);
        // Boundary cases named by the requirements.
        apply(0, 8'hFF, 8'h01);   // R1 carry out, zero low byte
        apply(1, 8'h33, 8'h33);   // R2 equal operands, no borrow
        apply(1, 8'h00, 8'h01);   // R2 borrow
        apply(2, 8'hFF, 8'hFF);   // R3 largest product
        apply(2, 8'h0F, 8'h11);   // R3 product fits in one byte
        apply(3, 8'h55, 8'hAA);   // R4 disjoint bits
        apply(4, 8'h55, 8'hAA);   // R5 all ones
        apply(5, 8'hFF, 8'hFF);   // R7 reserved codes ignore operands
        apply(6, 8'h80, 8'h01);   // R7
        apply(7, 8'h5A, 8'hC3);   // R7
        for (int op = 0; op < 8; op++) begin
            for (int i = 0; i < 7; i++) begin
                for (int j = 0; j < 7; j++) begin
                    apply(op, corner[i], corner[j]);
                end
            end
            for (int k = 0; k < 200; k++) begin
                apply(op, int'($urandom_range(255)), int'($urandom_range(255)));
            end
        end
        repeat (3) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run still active after %0d cycles, expected completion", WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule